// File: doc/BRIEF.md
# Trigger Pattern Time Multiplexer

This block turns the 96-channel hit pattern of one beam crossing into a stream of six 16-bit words for a serial trigger link. The 96 channels are six input cables of 16 channels each. One fast clock, running at six times the beam clock, drives the whole block. A one-cycle crossing strobe, aligned to that clock, marks the edge where the beam clock would capture.

On each strobe the block applies a per-channel mask and stores the result in one register. The mask has two parts: an enable vector, whose zero bits silence channels known to be bad, and an override vector, whose one bits force channels on so that test patterns can reach the trigger logic. A slot counter then sends the stored pattern one 16-bit word per fast cycle, lowest channels first. An alignment flag marks the first word of each crossing so the receiver can find word boundaries.

If no new strobe arrives after the sixth word, the counter wraps and the same pattern is sent again with the flag set. A strobe in the middle of a frame discards the rest of the old frame and starts the new pattern at its first word.

Top module: `trig_slot_mux`

## Requirements
- R1: After reset, and until the first crossing strobe, tx_word is 0 and tx_align is 0.
- R2: On a fast-clock edge with xing_stb high, the block stores the pattern (hit_pat AND chan_en) OR chan_ovr, bit by bit, for all 96 channels.
- R3: Slot s (s = 0..5) carries stored channels 16*s+15 down to 16*s on tx_word, with the lowest channel on bit 0. Slot 0 appears in the cycle that follows the capturing edge.
- R4: tx_align is 1 during slot 0 and 0 during slots 1 to 5.
- R5: Without a new strobe, the slot advances by one each fast cycle. After slot 5 it wraps to slot 0 and sends the stored pattern again.
- R6: A strobe during any slot makes the next cycle slot 0 of the newly captured pattern.
- R7: Changes on hit_pat, chan_en or chan_ovr while xing_stb is low do not affect tx_word.
- R8: A channel whose chan_en bit is 0 and whose chan_ovr bit is 0 is sent as 0. A channel whose chan_ovr bit is 1 is sent as 1, whatever its hit and enable bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Clock at six times the beam clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_stb | input | 1 | One-cycle crossing strobe; captures the pattern |
| hit_pat | input | 96 | Raw hit pattern, channel n on bit n |
| chan_en | input | 96 | Per-channel enable; 0 silences the channel |
| chan_ovr | input | 96 | Per-channel override; 1 forces the channel on |
| tx_word | output | 16 | Current 16-bit slot word |
| tx_align | output | 1 | High on slot 0 of each crossing |

## Verification
Two situations are hard to reach from the ports, because a well-behaved source never creates them. One is a missing strobe, which makes the frame wrap. The other is a strobe in the middle of a frame, which cuts it short. The bench creates both on purpose. It holds the strobe low for a seventh cycle to see the wrap, and it fires a new strobe at slot 2 of an open frame to see the restart. It also changes every data input while the strobe is low, and reads back all six slots, to show that the stored pattern did not move. Walking-one sweeps over hits, enables and overrides reach every channel in every slot position.

// File: rtl/trig_mux_pkg.sv
package trig_mux_pkg;

   // Output stage variant: combinational mux or an added flop stage.
   typedef enum int {
      OUT_COMB = 0,
      OUT_FLOP = 1
   } out_stage_e;

   // Lowest channel index carried by a given lane.
   function automatic int lane_base(input int lane, input int lane_w);
      return lane * lane_w;
   endfunction

endpackage

// File: rtl/tsm_mask_capture.sv
module tsm_mask_capture #(
   parameter int LANE_W  = 16,
   parameter int N_LANES = 6,
   localparam int PAT_W  = LANE_W * N_LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb_i,
   input  logic [PAT_W-1:0] hit_i,
   input  logic [PAT_W-1:0] en_i,
   input  logic [PAT_W-1:0] ovr_i,
   output logic [PAT_W-1:0] pat_o,
   output logic             live_o
);
   import trig_mux_pkg::*;

   logic [PAT_W-1:0] masked;

   // Mask logic, one generate slice per lane
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LO = lane_base(g, LANE_W);
      assign masked[LO +: LANE_W] =
         (hit_i[LO +: LANE_W] & en_i[LO +: LANE_W]) | ovr_i[LO +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pat_o  <= '0;
         live_o <= 1'b0;
      end else if (stb_i) begin
         pat_o  <= masked;
         live_o <= 1'b1;
      end
   end

   p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i |=> ((pat_o & $past(ovr_i)) == $past(ovr_i)));

   p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i |=> ((pat_o & ~$past(en_i) & ~$past(ovr_i)) == '0));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> $stable(pat_o));

endmodule

// File: rtl/tsm_slot_counter.sv
module tsm_slot_counter #(
   parameter int N_SLOTS = 6,
   localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_i,
   input  logic              live_i,
   output logic [SLOT_W-1:0] slot_o
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_SLOTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_o <= '0;
      end else if (stb_i) begin
         slot_o <= '0;
      end else if (live_i) begin
         slot_o <= (slot_o == LAST) ? '0 : slot_o + 1'b1;
      end
   end

   p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_o <= LAST);

   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (live_i && !stb_i && slot_o == LAST) |=> (slot_o == '0));

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (live_i && !stb_i && slot_o != LAST) |=> (slot_o == $past(slot_o) + 1'b1));

   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i |=> (slot_o == '0));

endmodule

// File: rtl/tsm_slot_select.sv
module tsm_slot_select #(
   parameter int LANE_W  = 16,
   parameter int N_SLOTS = 6,
   localparam int PAT_W  = LANE_W * N_SLOTS,
   localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
   input  logic [PAT_W-1:0]  pat_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              live_i,
   output logic [LANE_W-1:0] word_o,
   output logic              align_o
);
   import trig_mux_pkg::*;

   logic [LANE_W-1:0] lane_w [N_SLOTS];

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_word
      assign lane_w[s] = pat_i[lane_base(s, LANE_W) +: LANE_W];
   end

   always_comb begin
      word_o = '0;
      if (live_i) begin
         for (int s = 0; s < N_SLOTS; s++) begin
            if (slot_i == SLOT_W'(s)) word_o = lane_w[s];
         end
      end
   end

   assign align_o = live_i && (slot_i == '0);

   always_comb begin
      if (!live_i) p_idle_r1: assert (word_o == '0 && !align_o);
   end

endmodule

// File: rtl/trig_slot_mux.sv
module trig_slot_mux #(
   parameter int LANE_W  = 16,
   parameter int N_SLOTS = 6,
   parameter trig_mux_pkg::out_stage_e OUT_STAGE = trig_mux_pkg::OUT_COMB,
   localparam int PAT_W  = LANE_W * N_SLOTS,
   localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
   input  logic              clk_fast,
   input  logic              rst_n,
   input  logic              xing_stb,
   input  logic [PAT_W-1:0]  hit_pat,
   input  logic [PAT_W-1:0]  chan_en,
   input  logic [PAT_W-1:0]  chan_ovr,
   output logic [LANE_W-1:0] tx_word,
   output logic              tx_align
);
   import trig_mux_pkg::*;

   // Elaboration-time parameter checks
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be at least 1");
   end
   if (N_SLOTS < 2) begin : g_bad_slots
      $error("N_SLOTS must be at least 2");
   end

   logic [PAT_W-1:0]  pat_q;
   logic              live_q;
   logic [SLOT_W-1:0] slot_q;
   logic [LANE_W-1:0] mux_word;
   logic              mux_align;

   tsm_mask_capture #(.LANE_W(LANE_W), .N_LANES(N_SLOTS)) u_cap (
      .clk    (clk_fast),
      .rst_n  (rst_n),
      .stb_i  (xing_stb),
      .hit_i  (hit_pat),
      .en_i   (chan_en),
      .ovr_i  (chan_ovr),
      .pat_o  (pat_q),
      .live_o (live_q)
   );

   tsm_slot_counter #(.N_SLOTS(N_SLOTS)) u_cnt (
      .clk    (clk_fast),
      .rst_n  (rst_n),
      .stb_i  (xing_stb),
      .live_i (live_q),
      .slot_o (slot_q)
   );

   tsm_slot_select #(.LANE_W(LANE_W), .N_SLOTS(N_SLOTS)) u_sel (
      .pat_i   (pat_q),
      .slot_i  (slot_q),
      .live_i  (live_q),
      .word_o  (mux_word),
      .align_o (mux_align)
   );

   if (OUT_STAGE == OUT_FLOP) begin : g_flop
      always_ff @(posedge clk_fast) begin
         if (!rst_n) begin
            tx_word  <= '0;
            tx_align <= 1'b0;
         end else begin
            tx_word  <= mux_word;
            tx_align <= mux_align;
         end
      end
   end else begin : g_comb
      assign tx_word  = mux_word;
      assign tx_align = mux_align;
   end

   p_align_first_r4: assert property (@(posedge clk_fast) disable iff (!rst_n)
      mux_align |-> (slot_q == '0));

   p_first_slot_r3: assert property (@(posedge clk_fast) disable iff (!rst_n)
      xing_stb |=> (mux_word == pat_q[LANE_W-1:0]));

endmodule

// File: tb/trig_slot_mux_tb_top.sv
module trig_slot_mux_tb_top;
   localparam int LW = 16;
   localparam int NS = 6;
   localparam int PW = LW * NS;

   logic          clk_fast = 1'b0;
   logic          rst_n    = 1'b0;
   logic          xing_stb = 1'b0;
   logic [PW-1:0] hit_pat  = '0;
   logic [PW-1:0] chan_en  = '0;
   logic [PW-1:0] chan_ovr = '0;
   logic [LW-1:0] tx_word;
   logic          tx_align;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk_fast = ~clk_fast;

   trig_slot_mux dut_i (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .xing_stb (xing_stb),
      .hit_pat  (hit_pat),
      .chan_en  (chan_en),
      .chan_ovr (chan_ovr),
      .tx_word  (tx_word),
      .tx_align (tx_align)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [LW-1:0] slot_of(input logic [PW-1:0] p, input int s);
      logic [PW-1:0] sh;
      sh = p >> (LW * s);
      return sh[LW-1:0];
   endfunction

   // Check current output against slot s of pattern p
   task automatic chk_slot(input string req, input logic [PW-1:0] p, input int s);
      chk({req, " word"}, 32'(tx_word), 32'(slot_of(p, s)));
      chk("R4 align", 32'(tx_align), (s == 0) ? 32'd1 : 32'd0);
   endtask

   // Capture a crossing and walk its six slots; returns at slot 5
   task automatic frame(input string req, input logic [PW-1:0] h,
                        input logic [PW-1:0] e, input logic [PW-1:0] o);
      logic [PW-1:0] ex;
      ex = (h & e) | o;
      @(negedge clk_fast);
      hit_pat = h; chan_en = e; chan_ovr = o; xing_stb = 1'b1;
      @(negedge clk_fast);
      xing_stb = 1'b0;
      chk_slot(req, ex, 0);
      for (int s = 1; s < NS; s++) begin
         @(negedge clk_fast);
         chk_slot(req, ex, s);
      end
   endtask

   initial begin : watchdog
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk_fast);
         if (done) disable watchdog;
      end
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [PW-1:0] ones, pa, pb, px;
      logic [31:0]   seed;
      ones = '1;
      seed = 32'h1357_9bdf;

      // R1: reset state and idle before the first strobe
      repeat (3) @(negedge clk_fast);
      chk("R1 reset word", 32'(tx_word), 32'd0);
      chk("R1 reset align", 32'(tx_align), 32'd0);
      rst_n = 1'b1;
      hit_pat = ones; chan_en = ones; chan_ovr = ones;
      repeat (4) begin
         @(negedge clk_fast);
         chk("R1 idle word", 32'(tx_word), 32'd0);
         chk("R1 idle align", 32'(tx_align), 32'd0);
      end

      // R2/R3: walking single hit through every channel, all enabled
      for (int ch = 0; ch < PW; ch++) begin
         frame("R3 walk hit", PW'(1) << ch, ones, '0);
      end

      // R8: walking disabled channel over an all-hit pattern
      for (int ch = 0; ch < PW; ch++) begin
         frame("R8 mask off", ones, ~(PW'(1) << ch), '0);
      end

      // R8: walking override with no hits and nothing enabled
      for (int ch = 0; ch < PW; ch++) begin
         frame("R8 override", '0, '0, PW'(1) << ch);
      end

      // R2: pseudo-random mixes of hit, enable and override
      for (int n = 0; n < 40; n++) begin
         logic [PW-1:0] h, e, o;
         for (int k = 0; k < 3; k++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            h[k*32 +: 32] = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            e[k*32 +: 32] = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            o[k*32 +: 32] = seed & (seed >> 3);
         end
         frame("R2 mixed", h, e, o);
      end

      // R5: no new strobe after slot 5 -> wrap and resend
      pa = {6{16'hA5C3}} ^ {16'd5, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0};
      frame("R5 base", pa, ones, '0);
      for (int r = 0; r < 2; r++) begin
         for (int s = 0; s < NS; s++) begin
            @(negedge clk_fast);
            chk_slot("R5 wrap", pa, s);
         end
      end

      // R7: inputs change between strobes, output keeps stored pattern
      pb = {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666};
      @(negedge clk_fast);
      hit_pat = pb; chan_en = ones; chan_ovr = '0; xing_stb = 1'b1;
      @(negedge clk_fast);
      xing_stb = 1'b0;
      chk_slot("R7 base", pb, 0);
      hit_pat = ~pb; chan_en = '0; chan_ovr = {3{32'hF0F0_0F0F}};
      for (int s = 1; s < NS; s++) begin
         @(negedge clk_fast);
         hit_pat = PW'(s) * 96'h0123_4567_89AB;
         chk_slot("R7 hold", pb, s);
      end
      @(negedge clk_fast);
      chk_slot("R7 hold wrap", pb, 0);

      // R6: strobe during slot 2 restarts at slot 0 of new pattern
      px = {16'hBEEF, 16'hCAFE, 16'hF00D, 16'hD00D, 16'h7E57, 16'h0B0E};
      frame("R6 old", pb, ones, '0);
      @(negedge clk_fast);
      chk_slot("R6 old wrap", pb, 0);
      @(negedge clk_fast);
      chk_slot("R6 old", pb, 1);
      @(negedge clk_fast);
      chk_slot("R6 old", pb, 2);
      hit_pat = px; chan_en = ones; chan_ovr = '0; xing_stb = 1'b1;
      @(negedge clk_fast);
      xing_stb = 1'b0;
      chk_slot("R6 restart", px, 0);
      for (int s = 1; s < NS; s++) begin
         @(negedge clk_fast);
         chk_slot("R6 restart", px, s);
      end

      // R6: back-to-back strobes each restart at slot 0
      for (int n = 0; n < 4; n++) begin
         @(negedge clk_fast);
         hit_pat = PW'(n + 1) << (n * 20); chan_en = ones; chan_ovr = '0; xing_stb = 1'b1;
         @(negedge clk_fast);
         chk_slot("R6 back-to-back", PW'(n + 1) << (n * 20), 0);
         xing_stb = 1'b0;
      end

      // R1: reset mid-frame returns to idle
      @(negedge clk_fast);
      rst_n = 1'b0;
      @(negedge clk_fast);
      rst_n = 1'b1;
      @(negedge clk_fast);
      chk("R1 re-reset word", 32'(tx_word), 32'd0);
      chk("R1 re-reset align", 32'(tx_align), 32'd0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule